// File: doc/BRIEF.md
# Modem Handshake Line Controller

This block looks after the modem handshake signals of a single serial channel. It takes three active-low line inputs: carrier detect, clear to send, and a general-purpose sync input. Each input passes through a two-stage synchronizer and then a glitch filter. A level change is accepted only after the new level has been seen for `MIN_W` system clocks in a row. An accepted change is captured in a per-line status bit and flagged as a pending event. The event raises the interrupt output when its enable bit is set. Software clears all pending events with a one-cycle acknowledge pulse.

The block drives two active-low outputs, request to send and data terminal ready, from a control word that software writes. In asynchronous mode, request to send turns on at once but stays on after it is commanded off until the transmitter reports that it is completely empty. In synchronous mode it follows the command bit directly. With auto-enable set, the receiver enable is gated by the filtered carrier detect line and the transmitter enable is gated by the filtered clear-to-send line.

Top module: `modem_line_mgr`

## Requirements
- R1: After reset, `rts_n_o` and `dtr_n_o` are 1, `irq_o` is 0, `chg_o` is 0, and all control bits are 0, so every interrupt enable is off.
- R2: A line level must be held for at least `MIN_W` consecutive clocks to be accepted. A pulse of `MIN_W-1` clocks or fewer changes neither `stat_o` nor `chg_o`. A level held for `MIN_W` clocks is visible within `MIN_W+6` clocks. Line index 0 is carrier detect, 1 is clear to send and 2 is the sync input.
- R3: An accepted change sets `chg_o[i]` and latches the new level in `stat_o[i]`, where 1 means the line is low (asserted). While `chg_o[i]` is set, `stat_o[i]` holds its value. A pulse on `stat_ack_i` clears every `chg_o` bit, after which `stat_o` tracks the filtered level again.
- R4: `irq_o` is 1 exactly when some `chg_o[i]` is set and its enable bit `ctl_wdata_i[4+i]` was written as 1.
- R5: Changes on the sync input (index 2) set `chg_o[2]` only when the asynchronous-mode bit `ctl_wdata_i[3]` is 1.
- R6: With auto-enable `ctl_wdata_i[2]` set, `rx_en_o` is `rx_req_i` AND (filtered carrier detect is low). With auto-enable clear, `rx_en_o` equals `rx_req_i`.
- R7: With auto-enable set, `tx_en_o` is `tx_req_i` AND (filtered clear to send is low). With auto-enable clear, `tx_en_o` equals `tx_req_i`.
- R8: In asynchronous mode, `rts_n_o` goes to 0 one clock after the control register holds the RTS-on bit `ctl_wdata_i[1]` = 1.
- R9: In asynchronous mode, after RTS-on is cleared, `rts_n_o` stays 0 until `tx_empty_i` is 1. It goes to 1 on the clock after that.
- R10: In synchronous mode (`ctl_wdata_i[3]` = 0), `rts_n_o` is the inverse of the registered RTS-on bit, one clock later, whatever the value of `tx_empty_i`.
- R11: `dtr_n_o` is the inverse of the DTR-on bit `ctl_wdata_i[0]`, updated on the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcd_n_i | input | 1 | Carrier detect line, active low, asynchronous |
| cts_n_i | input | 1 | Clear to send line, active low, asynchronous |
| sync_n_i | input | 1 | General-purpose sync line, active low, asynchronous |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 7 | Control word: [0] DTR on, [1] RTS on, [2] auto-enable, [3] async mode, [6:4] per-line interrupt enables |
| stat_ack_i | input | 1 | Acknowledge pulse that clears all pending events |
| tx_empty_i | input | 1 | Transmitter buffer and shifter are both empty |
| rx_req_i | input | 1 | Software receiver enable |
| tx_req_i | input | 1 | Software transmitter enable |
| stat_o | output | 3 | Latched line levels, 1 = asserted (low) |
| chg_o | output | 3 | Pending change flags |
| irq_o | output | 1 | Interrupt request, active high |
| rx_en_o | output | 1 | Effective receiver enable |
| tx_en_o | output | 1 | Effective transmitter enable |
| rts_n_o | output | 1 | Request to send, active low |
| dtr_n_o | output | 1 | Data terminal ready, active low |

## Verification
The assertions assume that `stat_ack_i` and `ctl_we_i` are single-clock pulses applied synchronously. They also assume that `MIN_W` is at least 2, so the filter counter has a terminal value other than zero. The bench drives every input on the falling clock edge and holds each line level for a known whole number of clocks, so the accept/reject boundary of the filter falls on an exact cycle. Mode changes are made only through complete control-word writes, never in the middle of a filter interval that is being checked.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  localparam int NLINES = 3;
  localparam int IDX_DCD  = 0;
  localparam int IDX_CTS  = 1;
  localparam int IDX_SYNC = 2;

  typedef struct packed {
    logic [NLINES-1:0] ie;
    logic              async_mode;
    logic              auto_en;
    logic              rts_on;
    logic              dtr_on;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/mlm_in_filter.sv
module mlm_in_filter #(
  parameter int MIN_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n_i,
  output logic level_o,
  output logic event_o
);
  localparam int CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_W - 1);

  logic          s1_q, s2_q, filt_q, filt_d, ev_q, ev_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    ev_d   = 1'b0;
    if (s2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_d = s2_q;
      cnt_d  = '0;
      ev_d   = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
      ev_q   <= 1'b0;
    end else begin
      s1_q   <= line_n_i;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
      ev_q   <= ev_d;
    end
  end

  assign level_o = ~filt_q;
  assign event_o = ev_q;

  AST_FILT_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(cnt_q) == CNT_LAST); // R2
  AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q |-> filt_q != $past(filt_q)); // R3
endmodule

// File: rtl/mlm_event_latch.sv
module mlm_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic event_i,
  input  logic qual_i,
  input  logic ack_i,
  output logic stat_o,
  output logic chg_o
);
  logic stat_q, stat_d, chg_q, chg_d, stat_en;

  always_comb begin
    stat_en = ack_i | ~chg_q;
    stat_d  = level_i;
    chg_d   = (chg_q & ~ack_i) | (event_i & qual_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      chg_q <= chg_d;
    end
  end

  assign stat_o = stat_q;
  assign chg_o  = chg_q;

  AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !ack_i) |=> $stable(stat_q)); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(event_i && qual_i)) |=> !chg_q); // R3
endmodule

// File: rtl/mlm_rts_ctrl.sv
module mlm_rts_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic rts_on_i,
  input  logic tx_empty_i,
  output logic rts_act_o
);
  logic act_q, act_d;

  always_comb begin
    act_d = rts_on_i | (async_i & act_q & ~tx_empty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign rts_act_o = act_q;

  AST_RTS_ON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    rts_on_i |=> act_q); // R8
  AST_ASYNC_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (async_i && act_q && !tx_empty_i) |=> act_q); // R9
  AST_SYNC_RTS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_i && !rts_on_i) |=> !act_q); // R10
endmodule

// File: rtl/modem_line_mgr.sv
module modem_line_mgr
  import mlm_pkg::*;
#(
  parameter int MIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcd_n_i,
  input  logic              cts_n_i,
  input  logic              sync_n_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              stat_ack_i,
  input  logic              tx_empty_i,
  input  logic              rx_req_i,
  input  logic              tx_req_i,
  output logic [NLINES-1:0] stat_o,
  output logic [NLINES-1:0] chg_o,
  output logic              irq_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rts_n_o,
  output logic              dtr_n_o
);
  ctl_t              ctl_q, ctl_d;
  logic [NLINES-1:0] line_n, level, evt, qual;
  logic              rts_act;

  assign line_n = {sync_n_i, cts_n_i, dcd_n_i};

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i) ctl_d = ctl_t'(ctl_wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    qual           = '1;
    qual[IDX_SYNC] = ctl_q.async_mode;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    mlm_in_filter #(.MIN_W(MIN_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_n_i (line_n[i]),
      .level_o  (level[i]),
      .event_o  (evt[i])
    );
    mlm_event_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (level[i]),
      .event_i (evt[i]),
      .qual_i  (qual[i]),
      .ack_i   (stat_ack_i),
      .stat_o  (stat_o[i]),
      .chg_o   (chg_o[i])
    );
  end

  mlm_rts_ctrl u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_i    (ctl_q.async_mode),
    .rts_on_i   (ctl_q.rts_on),
    .tx_empty_i (tx_empty_i),
    .rts_act_o  (rts_act)
  );

  assign irq_o   = |(chg_o & ctl_q.ie);
  assign rx_en_o = rx_req_i & (~ctl_q.auto_en | level[IDX_DCD]);
  assign tx_en_o = tx_req_i & (~ctl_q.auto_en | level[IDX_CTS]);
  assign rts_n_o = ~rts_act;
  assign dtr_n_o = ~ctl_q.dtr_on;

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.auto_en && !level[IDX_DCD]) |-> !rx_en_o); // R6
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.auto_en && !level[IDX_CTS]) |-> !tx_en_o); // R7
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.async_mode && !chg_o[IDX_SYNC]) |=> !chg_o[IDX_SYNC]); // R5
  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.ie == '0) |-> !irq_o); // R4
endmodule

// File: tb/tb_modem_line_mgr.sv
module tb_modem_line_mgr;
  localparam int MIN_W = 8;
  localparam int SETTLE = MIN_W + 6;

  logic clk, rst_n;
  logic dcd_n, cts_n, sync_n, we, ack, tx_empty, rx_req, tx_req;
  logic [6:0] wdata;
  logic [2:0] stat, chg;
  logic irq, rx_en, tx_en, rts_n, dtr_n;
  int checks = 0;
  int errors = 0;

  modem_line_mgr #(.MIN_W(MIN_W)) dut (
    .clk(clk), .rst_n(rst_n), .dcd_n_i(dcd_n), .cts_n_i(cts_n),
    .sync_n_i(sync_n), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .stat_ack_i(ack), .tx_empty_i(tx_empty), .rx_req_i(rx_req),
    .tx_req_i(tx_req), .stat_o(stat), .chg_o(chg), .irq_o(irq),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rts_n_o(rts_n), .dtr_n_o(dtr_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input logic [2:0] ie, input logic asy,
                                    input logic aut, input logic rts, input logic dtr);
    return {ie, asy, aut, rts, dtr};
  endfunction

  task automatic wr_ctl(input logic [6:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 rts_n", rts_n, 1);
    check("R1 dtr_n", dtr_n, 1);
    check("R1 irq", irq, 0);
    check("R1 chg", chg, 0);
  endtask

  task automatic t_filter();
    wr_ctl(mk(3'b000, 0, 0, 0, 0));
    @(negedge clk); dcd_n = 1'b0;
    tick(MIN_W - 1); dcd_n = 1'b1;
    tick(SETTLE);
    check("R2 short pulse chg", chg, 0);
    check("R2 short pulse stat", stat, 0);
    dcd_n = 1'b0;
    tick(SETTLE);
    check("R2 accepted stat", stat[0], 1);
    check("R2 accepted chg", chg[0], 1);
    pulse_ack();
    check("R3 ack clears", chg, 0);
  endtask

  task automatic t_latch();
    dcd_n = 1'b1;
    tick(SETTLE);
    check("R3 latched new level", stat[0], 0);
    check("R3 flag set", chg[0], 1);
    dcd_n = 1'b0;
    tick(SETTLE);
    check("R3 held while pending", stat[0], 0);
    pulse_ack();
    check("R3 flag cleared", chg[0], 0);
    check("R3 tracks after ack", stat[0], 1);
  endtask

  task automatic t_irq();
    wr_ctl(mk(3'b010, 0, 0, 0, 0));
    dcd_n = 1'b1;
    tick(SETTLE);
    check("R4 masked change chg", chg[0], 1);
    check("R4 masked no irq", irq, 0);
    cts_n = 1'b0;
    tick(SETTLE);
    check("R4 enabled irq", irq, 1);
    pulse_ack();
    check("R4 irq after ack", irq, 0);
  endtask

  task automatic t_sync_in();
    wr_ctl(mk(3'b100, 0, 0, 0, 0));
    sync_n = 1'b0;
    tick(SETTLE);
    check("R5 sync mode no flag", chg[2], 0);
    check("R5 sync mode no irq", irq, 0);
    wr_ctl(mk(3'b100, 1, 0, 0, 0));
    sync_n = 1'b1;
    tick(SETTLE);
    check("R5 async flag", chg[2], 1);
    check("R5 async irq", irq, 1);
    pulse_ack();
  endtask

  task automatic t_auto();
    rx_req = 1'b1; tx_req = 1'b1;
    wr_ctl(mk(3'b000, 0, 1, 0, 0));
    tick(1);
    check("R6 rx gated by dcd", rx_en, 0);
    check("R7 tx open on cts", tx_en, 1);
    dcd_n = 1'b0; cts_n = 1'b1;
    tick(SETTLE);
    check("R6 rx open on dcd", rx_en, 1);
    check("R7 tx gated by cts", tx_en, 0);
    wr_ctl(mk(3'b000, 0, 0, 0, 0));
    check("R7 no auto tx", tx_en, 1);
    dcd_n = 1'b1;
    tick(SETTLE);
    check("R6 no auto rx", rx_en, 1);
    pulse_ack();
  endtask

  task automatic t_rts_async();
    tx_empty = 1'b0;
    wr_ctl(mk(3'b000, 1, 0, 1, 0));
    tick(1);
    check("R8 async rts on", rts_n, 0);
    wr_ctl(mk(3'b000, 1, 0, 0, 0));
    tick(10);
    check("R9 rts held until empty", rts_n, 0);
    tx_empty = 1'b1;
    tick(1);
    check("R9 rts released on empty", rts_n, 1);
  endtask

  task automatic t_rts_sync();
    tx_empty = 1'b0;
    wr_ctl(mk(3'b000, 0, 0, 1, 0));
    tick(1);
    check("R10 sync rts on", rts_n, 0);
    wr_ctl(mk(3'b000, 0, 0, 0, 0));
    tick(1);
    check("R10 sync rts off", rts_n, 1);
  endtask

  task automatic t_dtr();
    wr_ctl(mk(3'b000, 0, 0, 0, 1));
    check("R11 dtr on", dtr_n, 0);
    wr_ctl(mk(3'b000, 0, 0, 0, 0));
    check("R11 dtr off", dtr_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; dcd_n = 1'b1; cts_n = 1'b1; sync_n = 1'b1;
    we = 1'b0; wdata = '0; ack = 1'b0; tx_empty = 1'b1;
    rx_req = 1'b0; tx_req = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_filter();
    t_latch();
    t_irq();
    t_sync_in();
    t_auto();
    t_rts_async();
    t_rts_sync();
    t_dtr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule